// File: doc/BRIEF.md
# Windowed Watchdog Monitor

This block is a byte-wide watchdog that sits on a simple single-clock peripheral bus. Once software turns it on, an 8-bit up-counter starts from zero and advances once per clock. Software keeps the fault output quiet by writing a two-byte key to the service register. The second byte must follow the first within a bounded number of cycles. The key must also land while the counter is inside a window set by a lower and an upper compare value. A valid service restarts the counter.

Any misuse latches the fault output until reset. Misuse covers a wrong byte, a late second byte, a service that comes too early, or the counter passing the upper compare value. An optional external input pin, with selectable active level, can also force the fault. An interrupt request mirrors the fault while its enable bit is set. The enable, pin-level and pin-enable bits and both compare registers are one-shot configuration. An attempt to change them a second time is refused with a bus error in the same cycle.

Top module: `wdog_mon`

## Requirements
- R1: After reset, offset 0 (control) reads 0x00, offset 2 (lower compare) reads 0x00 and offset 3 (upper compare) reads 0xFF. Fault and interrupt are low. Control bit 0 is run enable, bit 1 is pin active level (0 = active low), bit 2 is pin enable and bit 3 is interrupt enable. Control bits 7:4 always read 0.
- R2: The first control write after reset sets bits 2:0. Any later control write whose bits 2:0 differ from the held ones raises bus_err in its write cycle and leaves them unchanged. A later write with equal bits 2:0 gives no error. Bit 3 takes the written value on every control write.
- R3: If the first control write leaves bit 0 at 0, the watchdog stays off until reset. The counter does not run, service writes are ignored, and the fault stays low.
- R4: Each compare register accepts one write after reset. A second write raises bus_err in its write cycle and leaves the stored value unchanged.
- R5: Offset 1 (service) always reads 0x00, and writes to it never raise bus_err.
- R6: A valid service is 0xB4 followed by 0x2C at offset 1, with the second write 1 to GAP_MAX (default 15) cycles after the first, while the counter is at or above the lower compare. It raises no fault and restarts the counter from zero.
- R7: A first service byte other than 0xB4, a second byte other than 0x2C, or a second byte more than GAP_MAX cycles after the first sets the fault.
- R8: A correct key whose second byte arrives while the counter is below the lower compare sets the fault.
- R9: The counter is zero after the enabling write and counts up by one per cycle, saturating at 0xFF. The fault is set when the counter is strictly above the upper compare. With upper compare H, the fault is first visible H+2 cycles after the enabling write edge. With H = 0xFF the counter never expires.
- R10: With run and pin enable set, the fault is set within 3 cycles of ext_in reaching the selected active level (two-stage synchronizer plus the fault register). With pin enable clear, ext_in has no effect.
- R11: The fault output stays high until reset once set. irq equals fault AND control bit 3, so writing bit 3 as 0 drops irq while the fault stays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register offset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| bus_err | output | 1 | Error response for the write in this cycle |
| ext_in | input | 1 | External fault request pin |
| fault_out | output | 1 | Latched watchdog fault |
| irq | output | 1 | Interrupt request |

## Verification
Directed service sequences are used to probe each failure path on its own:
- a wrong first byte and a wrong second byte;
- second-byte gaps of exactly GAP_MAX and GAP_MAX+1;
- a key completed below the lower compare and one completed inside the window.

An exact-cycle expiry test separates an off-by-one in the strict greater-than compare from a correct one. A late restart check shows that a valid service really reloads the counter.

Random trials then draw the compare values, the service start time, the byte gap and occasionally a corrupt second byte. The bench predicts the fault from arithmetic on those draws, so interactions between window, gap and expiry are covered. Pin tests use both active levels and pin enable off, which tells the polarity select apart from the enable gating.

// File: rtl/wdog_mon.sv
`timescale 1ns/1ps
module wdog_mon #(
  parameter int          GAP_MAX     = 15,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  KEY_FIRST   = 8'hB4,
  parameter logic [7:0]  KEY_SECOND  = 8'h2C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_we,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       bus_err,
  input  logic       ext_in,
  output logic       fault_out,
  output logic       irq
);
  localparam int GW = $clog2(GAP_MAX + 1);
  localparam logic [1:0] A_CTL = 2'd0, A_SVC = 2'd1, A_LO = 2'd2, A_HI = 2'd3;

  logic en_q, pol_q, pin_en_q, irq_en_q;
  logic ctl_lock_q, lo_lock_q, hi_lock_q;
  logic [7:0] cmp_lo_q, cmp_hi_q, cnt_q;
  logic armed_q;
  logic [GW-1:0] gap_q;
  logic fault_q;
  logic [SYNC_STAGES-1:0] sync_q;

  logic wr_ctl, wr_svc, wr_lo, wr_hi;
  logic ctl_take, ctl_bad, lo_bad, hi_bad;
  logic svc_wr, gap_late, first_bad, second_ok, second_bad;
  logic svc_early, expired, pin_hit, fault_set;

  assign wr_ctl = bus_we && bus_addr == A_CTL;
  assign wr_svc = bus_we && bus_addr == A_SVC;
  assign wr_lo  = bus_we && bus_addr == A_LO;
  assign wr_hi  = bus_we && bus_addr == A_HI;

  assign ctl_take = wr_ctl && !ctl_lock_q;
  assign ctl_bad  = wr_ctl && ctl_lock_q && (bus_wdata[2:0] != {pin_en_q, pol_q, en_q});
  assign lo_bad   = wr_lo && lo_lock_q;
  assign hi_bad   = wr_hi && hi_lock_q;
  assign bus_err  = ctl_bad || lo_bad || hi_bad;

  assign svc_wr     = wr_svc && en_q;
  assign gap_late   = armed_q && (gap_q == GW'(GAP_MAX));
  assign first_bad  = svc_wr && !armed_q && bus_wdata != KEY_FIRST;
  assign second_ok  = svc_wr && armed_q && !gap_late && bus_wdata == KEY_SECOND;
  assign second_bad = svc_wr && armed_q && !gap_late && bus_wdata != KEY_SECOND;
  assign svc_early  = second_ok && cnt_q < cmp_lo_q;
  assign expired    = en_q && cnt_q > cmp_hi_q;
  assign pin_hit    = en_q && pin_en_q && (sync_q[SYNC_STAGES-1] == pol_q);
  assign fault_set  = first_bad || second_bad || gap_late || svc_early || expired || pin_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      pol_q <= 1'b0;
      pin_en_q <= 1'b0;
      irq_en_q <= 1'b0;
      ctl_lock_q <= 1'b0;
    end else if (wr_ctl) begin
      irq_en_q <= bus_wdata[3];
      if (ctl_take) begin
        en_q <= bus_wdata[0];
        pol_q <= bus_wdata[1];
        pin_en_q <= bus_wdata[2];
        ctl_lock_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_lo_q <= 8'h00;
      cmp_hi_q <= 8'hFF;
      lo_lock_q <= 1'b0;
      hi_lock_q <= 1'b0;
    end else begin
      if (wr_lo && !lo_lock_q) begin
        cmp_lo_q <= bus_wdata;
        lo_lock_q <= 1'b1;
      end
      if (wr_hi && !hi_lock_q) begin
        cmp_hi_q <= bus_wdata;
        hi_lock_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      gap_q <= '0;
    end else if (gap_late) begin
      armed_q <= 1'b0;
      gap_q <= '0;
    end else if (svc_wr) begin
      armed_q <= !armed_q && bus_wdata == KEY_FIRST;
      gap_q <= '0;
    end else if (armed_q) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= 8'h00;
    else if ((ctl_take && bus_wdata[0]) || second_ok)
      cnt_q <= 8'h00;
    else if (en_q && cnt_q != 8'hFF)
      cnt_q <= cnt_q + 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      fault_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ext_in};
      if (fault_set) fault_q <= 1'b1;
    end
  end

  assign fault_out = fault_q;
  assign irq = fault_q && irq_en_q;

  always_comb begin
    case (bus_addr)
      A_CTL:   bus_rdata = {4'b0000, irq_en_q, pin_en_q, pol_q, en_q};
      A_LO:    bus_rdata = cmp_lo_q;
      A_HI:    bus_rdata = cmp_hi_q;
      default: bus_rdata = 8'h00;
    endcase
  end
endmodule

module wdog_mon_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_we,
  input logic       bus_err,
  input logic       fault_out,
  input logic       irq,
  input logic       en_q,
  input logic [7:0] cnt_q,
  input logic [7:0] cmp_hi_q
);
  // R11
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_out |=> fault_out);
  // R11
  irq_needs_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> fault_out);
  // R2
  err_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> bus_we);
  // R9
  expiry_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && cnt_q > cmp_hi_q) |=> fault_out);
  // R3
  idle_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !fault_out);
endmodule

bind wdog_mon wdog_mon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_err(bus_err),
  .fault_out(fault_out), .irq(irq), .en_q(en_q), .cnt_q(cnt_q), .cmp_hi_q(cmp_hi_q)
);

// File: tb/wdog_mon_test.sv
`timescale 1ns/1ps
module wdog_mon_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic ext_in = 1'b1;
  logic [7:0] bus_rdata;
  logic bus_err, fault_out, irq;
  int total = 0, bad = 0;
  bit done = 1'b0;

  wdog_mon uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .ext_in(ext_in), .fault_out(fault_out), .irq(irq));

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_we = 1'b0; ext_in = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, output logic e);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    #1 e = bus_err;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic bit predict(int h, int l, int a, int d, bit good_byte);
    return (h + 2 <= a + d) || (d > 15) || !good_byte || (a + d - 1 < l);
  endfunction

  initial begin
    logic e;
    logic [7:0] r;
    void'($urandom(32'd4242));
    do_reset();

    // R1 reset values
    rd(2'd0, r); chk("R1 ctl reset", r, 8'h00);
    rd(2'd2, r); chk("R1 lo reset", r, 8'h00);
    rd(2'd3, r); chk("R1 hi reset", r, 8'hFF);
    chk("R1 fault reset", fault_out, 1'b0);
    chk("R1 irq reset", irq, 1'b0);

    wr(2'd0, 8'hF1, e); chk("R2 first ctl err", e, 1'b0);
    rd(2'd0, r); chk("R1 reserved bits zero", r, 8'h01);
    wr(2'd0, 8'h03, e); chk("R2 changed ctl err", e, 1'b1);
    rd(2'd0, r); chk("R2 ctl unchanged", r, 8'h01);
    wr(2'd0, 8'h09, e); chk("R2 same-bits ctl err", e, 1'b0);
    rd(2'd0, r); chk("R2 irq bit taken", r, 8'h09);
    rd(2'd1, r); chk("R5 service reads zero", r, 8'h00);
    wr(2'd1, 8'hB4, e); chk("R5 service no err", e, 1'b0);
    wr(2'd1, 8'h2C, e);
    cyc(2); chk("R6 back-to-back key", fault_out, 1'b0);
    wr(2'd2, 8'h05, e); chk("R4 lo first err", e, 1'b0);
    wr(2'd2, 8'h06, e); chk("R4 lo second err", e, 1'b1);
    rd(2'd2, r); chk("R4 lo unchanged", r, 8'h05);
    wr(2'd3, 8'h40, e); chk("R4 hi first err", e, 1'b0);
    wr(2'd3, 8'h41, e); chk("R4 hi second err", e, 1'b1);
    rd(2'd3, r); chk("R4 hi unchanged", r, 8'h40);
    wr(2'd1, 8'h55, e);
    cyc(1); chk("R7 bad first byte", fault_out, 1'b1);
    chk("R11 irq with fault", irq, 1'b1);
    wr(2'd0, 8'h01, e); chk("R11 irq clear no err", e, 1'b0);
    chk("R11 irq dropped", irq, 1'b0);
    cyc(5); chk("R11 fault sticky", fault_out, 1'b1);

    // R7 bad second byte
    do_reset();
    wr(2'd0, 8'h01, e); wr(2'd1, 8'hB4, e); wr(2'd1, 8'h2D, e);
    cyc(1); chk("R7 bad second byte", fault_out, 1'b1);

    // R6 / R7 gap limit
    do_reset();
    wr(2'd0, 8'h01, e); wr(2'd1, 8'hB4, e);
    cyc(14); wr(2'd1, 8'h2C, e);
    cyc(2); chk("R6 gap of 15 ok", fault_out, 1'b0);
    wr(2'd1, 8'hB4, e);
    cyc(15); wr(2'd1, 8'h2C, e);
    cyc(1); chk("R7 gap of 16 late", fault_out, 1'b1);

    // R8 window low edge
    do_reset();
    wr(2'd2, 8'd10, e); wr(2'd0, 8'h01, e);
    wr(2'd1, 8'hB4, e); wr(2'd1, 8'h2C, e);
    cyc(1); chk("R8 early service", fault_out, 1'b1);
    do_reset();
    wr(2'd2, 8'd10, e); wr(2'd0, 8'h01, e);
    cyc(20); wr(2'd1, 8'hB4, e); wr(2'd1, 8'h2C, e);
    cyc(2); chk("R8 in-window service", fault_out, 1'b0);

    // R9 exact expiry
    do_reset();
    wr(2'd3, 8'd30, e); wr(2'd0, 8'h01, e);
    cyc(31); chk("R9 no fault at H+1", fault_out, 1'b0);
    cyc(1); chk("R9 fault at H+2", fault_out, 1'b1);
    do_reset();
    wr(2'd0, 8'h01, e);
    cyc(300); chk("R9 upper 0xFF never expires", fault_out, 1'b0);
    // R6 restart of counter
    do_reset();
    wr(2'd3, 8'd30, e); wr(2'd0, 8'h01, e);
    cyc(20); wr(2'd1, 8'hB4, e); wr(2'd1, 8'h2C, e);
    cyc(25); chk("R6 service restarts counter", fault_out, 1'b0);

    // R3 disabled forever
    do_reset();
    wr(2'd0, 8'h00, e); wr(2'd0, 8'h01, e); chk("R3 re-enable err", e, 1'b1);
    rd(2'd0, r); chk("R3 stays off", r, 8'h00);
    wr(2'd3, 8'd5, e); wr(2'd1, 8'h55, e);
    cyc(20); chk("R3 no fault when off", fault_out, 1'b0);

    // R10 pin
    do_reset();
    wr(2'd0, 8'h05, e);
    cyc(5); chk("R10 low-active idle", fault_out, 1'b0);
    @(negedge clk); ext_in = 1'b0;
    cyc(4); chk("R10 low-active hit", fault_out, 1'b1);
    do_reset();
    ext_in = 1'b0;
    wr(2'd0, 8'h07, e);
    cyc(5); chk("R10 high-active idle", fault_out, 1'b0);
    @(negedge clk); ext_in = 1'b1;
    cyc(4); chk("R10 high-active hit", fault_out, 1'b1);
    do_reset();
    wr(2'd0, 8'h01, e);
    @(negedge clk); ext_in = 1'b0;
    cyc(5); chk("R10 pin disabled ignored", fault_out, 1'b0);

    // random trials: R6 R7 R8 R9
    for (int it = 0; it < 40; it++) begin
      int h, l, a, d;
      bit good;
      logic [7:0] b2;
      h = 5 + int'($urandom_range(55));
      l = int'($urandom_range(h));
      a = 1 + int'($urandom_range(69));
      d = 1 + int'($urandom_range(19));
      good = ($urandom_range(3) != 0);
      b2 = good ? 8'h2C : (8'h2C ^ 8'(1 + $urandom_range(254)));
      do_reset();
      wr(2'd2, 8'(l), e); wr(2'd3, 8'(h), e); wr(2'd0, 8'h01, e);
      if (a > 1) cyc(a - 1);
      wr(2'd1, 8'hB4, e);
      if (d > 1) cyc(d - 1);
      wr(2'd1, b2, e);
      cyc(2);
      chk($sformatf("R6 R7 R8 R9 random h=%0d l=%0d a=%0d d=%0d", h, l, a, d),
          fault_out, predict(h, l, a, d, good));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired (all requirements) act=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule